// File: doc/BRIEF.md
# Nibble-Processor Add-with-Carry Execute Unit

This block is the add-with-carry execute stage of a small processor that works on 4-bit data. It accepts one decoded instruction per issue strobe and handles three forms of addition. The narrow form adds the 4-bit accumulator, a 4-bit data-memory operand and the carry flag, and returns the sum to the accumulator. The two wide forms add an 8-bit register pair and the 8-bit extended accumulator plus the carry flag. One wide form writes the extended accumulator. The other writes back to the chosen register pair. Operands are never written; the unit reports the sum, which destination to write, and the new carry flag.

The unit owns the carry flag. Two further decoded classes set or clear the flag directly. A narrow-form add retires in one cycle and a wide-form add in two. The `ready` output holds off the issuer while a wide add is still in flight. When a narrow-form add overflows, the unit remembers it. If the very next accepted instruction is an add-immediate-with-skip to the accumulator, the unit raises `skip` during that issue cycle so that the pipeline cancels the instruction. The wide forms never arm the skip, and neither does any other instruction.

Top module: `addc_exec_unit`

## Requirements
- R1: Class 1 (narrow add) gives `result[3:0]` = (A + M + C) mod 16, with `result[7:4]` = 0 and `dest_sel` = 1 (accumulator). Class codes are: 0 none, 1 narrow add, 2 extended-accumulator add, 3 pair add, 4 add-immediate-with-skip, 5 set carry, 6 clear carry, 7 other.
- R2: Class 2 gives `result` = (EA + RR + C) mod 256 with `dest_sel` = 2 (extended accumulator).
- R3: Class 3 gives the same 8-bit sum with `dest_sel` = 3 (register pair) and `dest_pair` equal to the `pair_sel` sampled at issue.
- R4: After an accepted add, `carry` equals the bit carried out of the top bit of that add. Class 5 sets `carry` and class 6 clears it. Every other accepted class leaves `carry` unchanged, and so does any cycle with no accepted issue.
- R5: `done` is high for exactly one cycle. For a narrow add it is the cycle after the issue edge. For a wide add it comes one cycle later, and both `done` and `ready` are low in the cycle between.
- R6: An issue strobe while `ready` is low is ignored. It changes neither the result, the destination nor the carry, and it does not arm a skip.
- R7: `skip` is high during an issue of class 4 exactly when the previous accepted instruction was a class-1 add that carried out.
- R8: `skip` stays low after a class-1 add without carry-out, and after a wide add that carries out. It also stays low after a class-4 instruction and when any other accepted instruction comes between the overflow and the class-4 issue.
- R9: While a synchronous reset is applied, the next state has `carry` = 0, `done` = 0, `ready` = 1, and no skip is pending.
- R10: With EA = 0xC3 and RR = 0xAA, a class-2 add gives 0x6E with carry 1 when C = 1, and 0x6D with carry 1 when C = 0. Neither arms a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Instruction issue strobe |
| op_class | input | 3 | Decoded operation class |
| acc_nib | input | 4 | Accumulator A |
| mem_nib | input | 4 | Data-memory operand |
| ext_acc | input | 8 | Extended accumulator EA |
| pair_val | input | 8 | Selected register pair value |
| pair_sel | input | 2 | Index of the selected register pair |
| result | output | 8 | Sum to be written back |
| dest_sel | output | 2 | Destination: 0 none, 1 A, 2 EA, 3 pair |
| dest_pair | output | 2 | Pair index for destination 3 |
| carry | output | 1 | Carry flag |
| skip | output | 1 | Cancel the add-immediate-with-skip now issuing |
| done | output | 1 | Add retired this cycle; result is valid |
| ready | output | 1 | Unit can accept an issue this cycle |

## Verification
The assertions assume three things about the inputs. `op_class` holds one of the eight listed codes. The issuer keeps `issue` and the operands stable from one falling clock edge to the next. The reset is long enough to cover a whole clock edge. The bench drives every input on the falling edge and holds it through the rising edge. It issues only defined classes. It deliberately raises `issue` while `ready` is low, so that the ignore rule is exercised rather than assumed.

// File: rtl/addc_pkg.sv
package addc_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_ADD_MEM  = 3'd1,
    OP_ADD_EXT  = 3'd2,
    OP_ADD_PAIR = 3'd3,
    OP_ADS_IMM  = 3'd4,
    OP_SET_C    = 3'd5,
    OP_CLR_C    = 3'd6,
    OP_OTHER    = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_EXT  = 2'd2,
    DST_PAIR = 2'd3
  } dest_e;

endpackage

// File: rtl/addc_adder.sv
module addc_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic logic [W:0] add_with_carry(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] full;
  assign full = add_with_carry(a, b, cin);
  assign sum  = full[W-1:0];
  assign cout = full[W];

endmodule

// File: rtl/addc_cycle_ctr.sv
module addc_cycle_ctr #(
  parameter int CYC_SHORT = 1,
  parameter int CYC_LONG  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_form,
  output logic done,
  output logic ready
);

  localparam int CNT_W = $clog2(CYC_LONG + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= long_form ? CNT_W'(CYC_LONG) : CNT_W'(CYC_SHORT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done  = (cnt_q == CNT_W'(1));
  assign ready = (cnt_q <= CNT_W'(1));

  assert_short_done_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !long_form) |=> done);

  generate
    if (CYC_LONG == 2) begin : g_long_chk
      assert_long_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (load && long_form) |=> (!done && !ready));
      assert_long_done_R5: assert property (@(posedge clk) disable iff (rst)
        (load && long_form) |=> ##1 done);
    end
  endgenerate

  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !done);

endmodule

// File: rtl/addc_skip_track.sv
module addc_skip_track
  import addc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  op_class_e op,
  input  logic      nib_cout,
  output logic      skip,
  output logic      pend
);

  logic pend_q;
  logic arm_now;

  assign arm_now = accept && (op == OP_ADD_MEM) && nib_cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= arm_now;
    end
  end

  assign skip = accept && (op == OP_ADS_IMM) && pend_q;
  assign pend = pend_q;

  assert_pend_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(accept && op == OP_ADD_MEM && nib_cout));

  assert_no_skip_after_wide_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_ADD_EXT || op == OP_ADD_PAIR)) |=> !skip);

  assert_no_chain_after_ads_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_ADS_IMM) |=> !skip);

endmodule

// File: rtl/addc_exec_unit.sv
module addc_exec_unit
  import addc_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int PAIR_SEL_W = 2,
  parameter int CYC_SHORT  = 1,
  parameter int CYC_LONG   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic [2:0]            op_class,
  input  logic [NIB_W-1:0]      acc_nib,
  input  logic [NIB_W-1:0]      mem_nib,
  input  logic [2*NIB_W-1:0]    ext_acc,
  input  logic [2*NIB_W-1:0]    pair_val,
  input  logic [PAIR_SEL_W-1:0] pair_sel,
  output logic [2*NIB_W-1:0]    result,
  output logic [1:0]            dest_sel,
  output logic [PAIR_SEL_W-1:0] dest_pair,
  output logic                  carry,
  output logic                  skip,
  output logic                  done,
  output logic                  ready
);

  localparam int PAIR_W = 2 * NIB_W;

  op_class_e op;
  assign op = op_class_e'(op_class);

  logic accept;
  logic is_nib;
  logic is_wide;
  logic carry_touch;
  logic pend;

  assign accept      = issue && ready;
  assign is_nib      = (op == OP_ADD_MEM);
  assign is_wide     = (op == OP_ADD_EXT) || (op == OP_ADD_PAIR);
  assign carry_touch = accept && (is_nib || is_wide || op == OP_SET_C || op == OP_CLR_C);

  logic                  carry_q;
  logic [NIB_W-1:0]      nib_sum;
  logic                  nib_cout;
  logic [PAIR_W-1:0]     wide_sum;
  logic                  wide_cout;

  addc_adder #(.W(NIB_W)) u_nib_add (
    .a    (acc_nib),
    .b    (mem_nib),
    .cin  (carry_q),
    .sum  (nib_sum),
    .cout (nib_cout)
  );

  addc_adder #(.W(PAIR_W)) u_wide_add (
    .a    (ext_acc),
    .b    (pair_val),
    .cin  (carry_q),
    .sum  (wide_sum),
    .cout (wide_cout)
  );

  addc_cycle_ctr #(.CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept && (is_nib || is_wide)),
    .long_form (is_wide),
    .done      (done),
    .ready     (ready)
  );

  addc_skip_track u_skip (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .op       (op),
    .nib_cout (nib_cout),
    .skip     (skip),
    .pend     (pend)
  );

  logic [PAIR_W-1:0]     res_q;
  dest_e                 dst_q;
  logic [PAIR_SEL_W-1:0] pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      res_q   <= '0;
      dst_q   <= DST_NONE;
      pair_q  <= '0;
    end else if (accept) begin
      unique case (op)
        OP_ADD_MEM: begin
          carry_q <= nib_cout;
          res_q   <= {{(PAIR_W-NIB_W){1'b0}}, nib_sum};
          dst_q   <= DST_ACC;
          pair_q  <= pair_sel;
        end
        OP_ADD_EXT, OP_ADD_PAIR: begin
          carry_q <= wide_cout;
          res_q   <= wide_sum;
          dst_q   <= (op == OP_ADD_EXT) ? DST_EXT : DST_PAIR;
          pair_q  <= pair_sel;
        end
        OP_SET_C: carry_q <= 1'b1;
        OP_CLR_C: carry_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign result    = res_q;
  assign dest_sel  = dst_q;
  assign dest_pair = pair_q;
  assign carry     = carry_q;

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!carry_q && !done && ready && !pend));

  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !carry_touch |=> $stable(carry_q));

  assert_nib_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (done && dst_q == DST_ACC) |-> (res_q[PAIR_W-1:NIB_W] == '0));

  assert_ignored_issue_R6: assert property (@(posedge clk) disable iff (rst)
    (issue && !ready) |=> ($stable(res_q) && $stable(carry_q) && $stable(dst_q)));

  assert_skip_only_on_ads_R7: assert property (@(posedge clk) disable iff (rst)
    skip |-> (issue && op == OP_ADS_IMM && pend));

endmodule

// File: tb/sim_addc_exec_unit.sv
`timescale 1ns/1ps
module sim_addc_exec_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       issue;
  logic [2:0] op_class;
  logic [3:0] acc_nib, mem_nib;
  logic [7:0] ext_acc, pair_val;
  logic [1:0] pair_sel;
  logic [7:0] result;
  logic [1:0] dest_sel, dest_pair;
  logic       carry, skip, done, ready;

  int errors = 0;
  int checks = 0;
  logic seen_skip;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  addc_exec_unit u0 (
    .clk(clk), .rst(rst), .issue(issue), .op_class(op_class),
    .acc_nib(acc_nib), .mem_nib(mem_nib), .ext_acc(ext_acc),
    .pair_val(pair_val), .pair_sel(pair_sel), .result(result),
    .dest_sel(dest_sel), .dest_pair(dest_pair), .carry(carry),
    .skip(skip), .done(done), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge.
  task automatic issue_op(input int op, input int a, input int m,
                          input int ea, input int rr, input int sel);
    issue    = 1'b1;
    op_class = op[2:0];
    acc_nib  = a[3:0];
    mem_nib  = m[3:0];
    ext_acc  = ea[7:0];
    pair_val = rr[7:0];
    pair_sel = sel[1:0];
    #1 seen_skip = skip;
    @(posedge clk);
    @(negedge clk);
    issue    = 1'b0;
    op_class = 3'd0;
  endtask

  task automatic set_c(input int c);
    issue_op(c != 0 ? 5 : 6, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s, exp_res, exp_c;
    rst = 1'b1; issue = 1'b0; op_class = 3'd0;
    acc_nib = 0; mem_nib = 0; ext_acc = 0; pair_val = 0; pair_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 carry", carry, 0);
    check("R9 done", done, 0);
    check("R9 ready", ready, 1);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R9 no pending skip", seen_skip, 0);

    // R1 R4 R7 R8 exhaustive narrow-form sweep
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int m = 0; m < 16; m++) begin
          set_c(c);
          check("R4 set/clear carry", carry, c);
          issue_op(1, a, m, 0, 0, 0);
          s = a + m + c;
          check("R1 narrow sum", result, s % 16);
          check("R1 dest acc", dest_sel, 1);
          check("R5 narrow done", done, 1);
          check("R4 narrow carry", carry, s / 16);
          issue_op(4, 0, 0, 0, 0, 0);
          if (s >= 16) check("R7 skip after overflow", seen_skip, 1);
          else         check("R8 no skip without overflow", seen_skip, 0);
          check("R4 carry held by ads", carry, s / 16);
        end
      end
    end

    // R2 R3 R5 R6 R8 wide-form sweep
    for (int form = 2; form < 4; form++) begin
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < 16; i++) begin
          for (int j = 0; j < 16; j++) begin
            int ea, rr, sel;
            ea  = i * 17;
            rr  = (ea * 7 + j * 29) % 256;
            sel = (i + j) % 4;
            set_c(c);
            issue_op(form, 0, 0, ea, rr, sel);
            check("R5 wide gap done", done, 0);
            check("R5 wide gap ready", ready, 0);
            // R6: narrow add offered while not ready, would overflow
            issue_op(1, 15, 15, 0, 0, 0);
            s = ea + rr + c;
            exp_res = s % 256;
            exp_c   = s / 256;
            check("R5 wide done", done, 1);
            check("R6 ignored issue keeps carry", carry, exp_c);
            if (form == 2) begin
              check("R2 wide sum", result, exp_res);
              check("R2 dest ext", dest_sel, 2);
            end else begin
              check("R3 pair sum", result, exp_res);
              check("R3 dest pair", dest_sel, 3);
              check("R3 pair index", dest_pair, sel);
            end
            issue_op(4, 0, 0, 0, 0, 0);
            check("R8 no skip after wide", seen_skip, 0);
          end
        end
      end
    end

    // R8 pending cleared by an intervening instruction
    set_c(0);
    issue_op(1, 15, 1, 0, 0, 0);
    check("R4 overflow carry", carry, 1);
    issue_op(0, 0, 0, 0, 0, 0);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R8 intervening clears skip", seen_skip, 0);

    // R7 R8 ads does not chain
    set_c(0);
    issue_op(1, 9, 9, 0, 0, 0);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R7 skip after overflow", seen_skip, 1);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R8 no chain after ads", seen_skip, 0);

    // R8 narrow overflow then wide add clears pending
    set_c(1);
    issue_op(1, 8, 8, 0, 0, 0);
    issue_op(2, 0, 0, 1, 1, 0);
    @(negedge clk);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R8 wide clears pending", seen_skip, 0);

    // R10 worked example
    set_c(1);
    issue_op(2, 0, 0, 8'hC3, 8'hAA, 0);
    @(negedge clk);
    check("R10 sum with carry", result, 8'h6E);
    check("R10 carry", carry, 1);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R10 no skip", seen_skip, 0);
    set_c(0);
    issue_op(2, 0, 0, 8'hC3, 8'hAA, 0);
    @(negedge clk);
    check("R10 sum without carry", result, 8'h6D);
    check("R10 carry", carry, 1);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R10 no skip", seen_skip, 0);

    // R9 reset mid-run
    set_c(0);
    issue_op(1, 15, 15, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 carry after reset", carry, 0);
    check("R9 ready after reset", ready, 1);
    issue_op(4, 0, 0, 0, 0, 0);
    check("R9 pending cleared", seen_skip, 0);

    finish_run();
  end

endmodule